// File: doc/BRIEF.md
# Glitch-Free Multi-Ratio Clock Generator

This block turns one fast bus clock into a slower cache clock, at half the bus rate, and four core clocks. The core clocks run at the cache rate divided by 1, 2, 3 or 4. A 2-bit ratio select picks the divisor. A core that is itself clocked by one of these outputs drives that select, so no output may ever carry a short pulse, and that includes the moment the ratio changes.

Every output is a flop on the bus clock. No output passes through a combinational mux. The select is resynchronised into a shadow register. A new ratio is adopted only where the current core period ends and all counters return to zero. The core outputs then rest low for one full cache period before the first pulse of the new ratio. Reset asserts asynchronously and deasserts through a two-flop synchroniser. After release, a short gating window keeps every output low so that the first pulse has full width.

The block has no data path, so it has no valid/ready interface. Its pins are plain clock and control signals.

Top module: `gclk_gen`

## Requirements
- R1: Once running, `clk_cache` toggles on every bus clock edge: high for one bus cycle, then low for one bus cycle.
- R2: Ratio select encoding: 0 gives 1:1, 1 gives 1:2, 2 gives 1:3 and 3 gives 1:4 relative to `clk_cache`. For select value m, with N = m+1, a core clock is high for N bus cycles and then low for N bus cycles.
- R3: Every rising edge of a core clock falls on the same bus edge as a rising edge of `clk_cache`.
- R4: The four bits of `clk_core` are identical in every cycle.
- R5: `mode_sel` passes through two synchronising flops. A new value takes effect only after the last low cycle of the current core period. While the core clock is high, the active ratio never changes.
- R6: When the adopted ratio differs from the active one, the core outputs stay low for two extra bus cycles (one cache period) before the first high cycle of the new ratio.
- R7: No core clock high pulse is shorter than one bus cycle or longer than four bus cycles.
- R8: While `rst_async_n` is low, all outputs are low. After release, all outputs stay low through the third bus edge and rise together on the fourth.
- R9: Writing the value that is already active causes no gap: the core period continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast source clock |
| rst_async_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Core ratio select, may change at any time |
| clk_cache | output | 1 | Bus clock divided by two |
| clk_core | output | 4 | Core clocks, all at the selected ratio |

## Verification
The bound checker watches, on every cycle, the following properties:
- the cache clock keeps alternating;
- core rising edges align with cache rising edges;
- the four core outputs stay equal;
- no high pulse runs past four bus cycles;
- the active ratio never changes while a core clock is high.

Some behaviour can only be shown by the bench's scenarios against its cycle model:
- the exact period for each ratio;
- the length of the gap on a ratio change;
- the position of the first pulse after reset;
- the absence of a gap when the same value is rewritten;
- behaviour under rapid select changes and a reset in mid-run.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
  localparam int MODE_W   = 2;
  localparam int MAX_HALF = 1 << MODE_W;
  localparam int PH_W     = $clog2(2 * MAX_HALF);
  localparam int GAP_LEN  = 2;
  localparam int GAP_W    = (GAP_LEN > 1) ? $clog2(GAP_LEN) : 1;
  localparam int N_CORES  = 4;
  localparam int SYNC_STAGES = 2;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [PH_W-1:0]   phase_t;

  function automatic phase_t half_of(mode_t m);
    return phase_t'(m) + phase_t'(1);
  endfunction

  function automatic phase_t last_of(mode_t m);
    logic [PH_W:0] full;
    full = ({1'b0, half_of(m)} << 1) - (PH_W+1)'(1);
    return full[PH_W-1:0];
  endfunction
endpackage

// File: rtl/gclk_rst_sync.sv
module gclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain[STAGES-1];
endmodule

// File: rtl/gclk_mode_shadow.sv
module gclk_mode_shadow
  import gclk_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_i,
  output mode_t mode_o
);
  mode_t stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= mode_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign mode_o = stage_q[STAGES-1];
endmodule

// File: rtl/gclk_seq.sv
module gclk_seq
  import gclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  mode_t  pend_mode,
  output logic   run_nx,
  output phase_t ph_nx,
  output mode_t  cur_nx,
  output logic   started_nx,
  output mode_t  cur_q_o
);
  logic            run_q, started_q;
  logic [GAP_W-1:0] gap_q, gap_nx;
  phase_t          ph_q;
  mode_t           cur_q;

  always_comb begin
    run_nx     = run_q;
    started_nx = started_q;
    gap_nx     = gap_q;
    ph_nx      = ph_q;
    cur_nx     = cur_q;
    if (!run_q) begin
      if (gap_q == '0) cur_nx = pend_mode;
      if (gap_q == GAP_W'(GAP_LEN - 1)) begin
        gap_nx     = '0;
        run_nx     = 1'b1;
        started_nx = 1'b1;
        ph_nx      = '0;
      end else begin
        gap_nx = gap_q + GAP_W'(1);
      end
    end else if (ph_q == last_of(cur_q)) begin
      ph_nx = '0;
      if (pend_mode != cur_q) begin
        run_nx = 1'b0;
        gap_nx = '0;
      end
    end else begin
      ph_nx = ph_q + phase_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      started_q <= 1'b0;
      gap_q     <= '0;
      ph_q      <= '0;
      cur_q     <= '0;
    end else begin
      run_q     <= run_nx;
      started_q <= started_nx;
      gap_q     <= gap_nx;
      ph_q      <= ph_nx;
      cur_q     <= cur_nx;
    end
  end

  assign cur_q_o = cur_q;
endmodule

// File: rtl/gclk_out_stage.sv
module gclk_out_stage
  import gclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_nx,
  input  phase_t             ph_nx,
  input  mode_t              cur_nx,
  input  logic               started_nx,
  output logic               cache_o,
  output logic [N_CORES-1:0] core_o
);
  logic core_hi_nx;
  assign core_hi_nx = run_nx && (ph_nx < half_of(cur_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cache_o <= 1'b0;
    else        cache_o <= started_nx ? ~cache_o : 1'b0;
  end

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) core_o[g] <= 1'b0;
      else        core_o[g] <= core_hi_nx;
    end
  end
endmodule

// File: rtl/gclk_gen.sv
module gclk_gen
  import gclk_pkg::*;
(
  input  logic               clk_bus,
  input  logic               rst_async_n,
  input  logic [MODE_W-1:0]  mode_sel,
  output logic               clk_cache,
  output logic [N_CORES-1:0] clk_core
);
  logic   rst_sync_n;
  mode_t  pend_mode, cur_mode, cur_nx;
  logic   run_nx, started_nx;
  phase_t ph_nx;

  gclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_bus), .arst_n(rst_async_n), .rst_n_o(rst_sync_n)
  );

  gclk_mode_shadow #(.STAGES(SYNC_STAGES)) u_shadow (
    .clk(clk_bus), .rst_n(rst_sync_n), .mode_i(mode_sel), .mode_o(pend_mode)
  );

  gclk_seq u_seq (
    .clk(clk_bus), .rst_n(rst_sync_n), .pend_mode(pend_mode),
    .run_nx(run_nx), .ph_nx(ph_nx), .cur_nx(cur_nx),
    .started_nx(started_nx), .cur_q_o(cur_mode)
  );

  gclk_out_stage u_out (
    .clk(clk_bus), .rst_n(rst_sync_n), .run_nx(run_nx), .ph_nx(ph_nx),
    .cur_nx(cur_nx), .started_nx(started_nx),
    .cache_o(clk_cache), .core_o(clk_core)
  );
endmodule

// File: rtl/gclk_checker.sv
module gclk_checker
  import gclk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clk_cache,
  input logic [N_CORES-1:0] clk_core,
  input mode_t              cur_mode
);
  logic [2:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= '0;
    else if (!clk_core[0]) hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  a_r1_cache_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    clk_cache |=> !clk_cache);

  a_r1_cache_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_cache) |=> clk_cache);

  a_r3_core_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_core[0]) |-> $rose(clk_cache));

  a_r4_cores_equal: assert property (@(posedge clk) disable iff (!rst_n)
    clk_core == {N_CORES{clk_core[0]}});

  a_r5_ratio_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_mode) |-> !clk_core[0]);

  a_r7_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    clk_core[0] |-> hi_cnt < 3'd4);
endmodule

bind gclk_gen gclk_checker u_chk (
  .clk(clk_bus), .rst_n(rst_sync_n), .clk_cache(clk_cache),
  .clk_core(clk_core), .cur_mode(cur_mode)
);

// File: tb/gclk_gen_tb.sv
module gclk_gen_tb;
  logic       clk_bus = 1'b0;
  logic       rst_async_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       clk_cache;
  logic [3:0] clk_core;

  int checks = 0, failures = 0, cyc = 0;

  gclk_gen u_dut (
    .clk_bus(clk_bus), .rst_async_n(rst_async_n), .mode_sel(mode_sel),
    .clk_cache(clk_cache), .clk_core(clk_core)
  );

  always #4 clk_bus = ~clk_bus;

  // behavioural reference model
  int  rel = 0, sh1 = 0, sh2 = 0, m_gap = 0, m_ph = 0, m_cur = 0;
  bit  m_run = 0, m_started = 0, e_cache = 0, e_core = 0;

  always @(posedge clk_bus) begin
    cyc++;
    if (!rst_async_n) begin
      rel = 0; sh1 = 0; sh2 = 0; m_gap = 0; m_ph = 0; m_cur = 0;
      m_run = 0; m_started = 0; e_cache = 0; e_core = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      int adopt;
      adopt = sh2; sh2 = sh1; sh1 = int'(mode_sel);
      if (!m_run) begin
        if (m_gap == 0) begin m_cur = adopt; m_gap = 1; end
        else begin m_gap = 0; m_run = 1; m_ph = 0; m_started = 1; end
      end else if (m_ph == 2 * (m_cur + 1) - 1) begin
        m_ph = 0;
        if (adopt != m_cur) begin m_run = 0; m_gap = 0; end
      end else begin
        m_ph++;
      end
      e_cache = m_started ? !e_cache : 1'b0;
      e_core  = m_run && (m_ph < m_cur + 1);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison and pulse monitors, sampled on the falling edge
  bit prev_core = 0, prev_cache = 0;
  int hi_w = 0;
  always @(negedge clk_bus) begin
    check(clk_cache == e_cache, "R1 cache", clk_cache, e_cache);
    check(clk_core[0] == e_core, "R2 R5 R6 R9 core", clk_core[0], e_core);
    check(clk_core == {4{clk_core[0]}}, "R4 equal", clk_core, {4{clk_core[0]}});
    if (clk_core[0] && !prev_core)
      check(clk_cache && !prev_cache, "R3 aligned", clk_cache, 1);
    if (clk_core[0]) hi_w++;
    else begin
      if (prev_core) check(hi_w >= 1 && hi_w <= 4, "R7 width", hi_w, 4);
      hi_w = 0;
    end
    prev_core = clk_core[0];
    prev_cache = clk_cache;
  end

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk_bus) if (cyc > 100000) begin
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    finish_tb();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_bus);
    #1;
  endtask

  task automatic release_and_check_start();
    rst_async_n = 1'b1;
    // edges 1..3 after release: outputs low
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk_bus);
      check(clk_cache == 0 && clk_core == 0, "R8 gated", {clk_cache, clk_core}, 0);
    end
    @(negedge clk_bus);
    check(clk_cache == 1 && clk_core == 4'hF, "R8 first pulse", {clk_cache, clk_core}, 31);
    #1;
  endtask

  initial begin
    wait_cyc(5);
    check(clk_cache == 0 && clk_core == 0, "R8 reset", {clk_cache, clk_core}, 0);
    release_and_check_start();
    wait_cyc(30);
    mode_sel = 2'd1; wait_cyc(40);
    mode_sel = 2'd2; wait_cyc(50);
    mode_sel = 2'd3; wait_cyc(60);
    mode_sel = 2'd3; wait_cyc(30);   // R9 same value rewritten
    mode_sel = 2'd0; wait_cyc(20);
    for (int i = 0; i < 20; i++) begin
      mode_sel = 2'(i % 4); wait_cyc(3);
    end
    mode_sel = 2'd1; wait_cyc(40);
    mode_sel = 2'd2; wait_cyc(13);
    rst_async_n = 1'b0;
    #1;
    check(clk_cache == 0 && clk_core == 0, "R8 async reset", {clk_cache, clk_core}, 0);
    wait_cyc(4);
    check(clk_cache == 0 && clk_core == 0, "R8 held", {clk_cache, clk_core}, 0);
    release_and_check_start();
    wait_cyc(60);
    finish_tb();
  end
endmodule